// File: doc/BRIEF.md
# MDIO Management Master

This block is a station-management master for Ethernet PHYs. Software controls it through one 32-bit command/status word. A write to that word with the busy bit set starts a management frame. The frame is either a Clause 22 frame or a Clause 45 frame, as the frame-type field selects. The block shifts the frame out on MDC/MDIO and, for reads, samples the reply from the PHY. When the frame has finished on the wire it clears busy. After a read, the low sixteen bits of the same word hold the value the PHY returned. A Clause 45 access takes two commands: an address frame first, then a write, read, or read-with-increment frame. The block keeps its own copy of the Clause 45 register address. That copy follows each address frame and each incrementing read, and it is visible on `c45_ptr`.

Command word layout:

| Bits | Content |
| --- | --- |
| 31 | busy (set by software to start a frame) |
| 30 | ready (read-only) |
| 29:25 | register address (Clause 22) or device address (Clause 45) |
| 24:20 | PHY address |
| 19:18 | opcode |
| 17:16 | frame type |
| 15:0 | write data, Clause 45 address, or read result |

The controller is a single state machine with these states:
- `ST_IDLE`: MDC is held low and MDIO is released.
- `ST_PREAMBLE`: 32 bit times of ones.
- `ST_HEADER`: 14 bits, made up of the start code, opcode, PHY address and register/device field.
- `ST_TURN`: 2 bit times.
- `ST_DATA`: 16 bit times.

The transitions are:
- IDLE→PREAMBLE on an accepted command.
- PREAMBLE→HEADER, HEADER→TURN and TURN→DATA, each on the MDC falling edge that ends the last bit of the state.
- DATA→IDLE on the falling edge that ends bit 16. Busy clears on this transition and any read result is stored.

One MDC period is 2×`HALF_CYC` system clocks. The default of 20 gives 2.5 MHz from a 100 MHz clock.

Top module: `mdio_master`

## Requirements
- R1: While idle, a write with bit 31 = 1 and frame type (bits 17:16) equal to 1 (Clause 22) or 0 (Clause 45) starts a frame. Bit 31 then reads 1 until the frame ends. Bit 30 reads as the inverse of bit 31, and reset leaves the word at 0x4000_0000.
- R2: While idle, a write with bit 31 = 0, or with frame type 2 or 3, is ignored. The word is unchanged, busy stays 0 and MDC stays low.
- R3: A write while busy is 1 is ignored. Bits 29:16 keep the accepted command and the frame on the wire is unaffected.
- R4: Every frame begins with 32 ones. These are followed by the start code (01 for Clause 22, 00 for Clause 45), then opcode bits 19:18, then PHY address bits 24:20, then bits 29:25. Each field is sent MSB first.
- R5: A frame whose opcode bit 19 is 0 is a write or Clause 45 address frame. In this frame the master drives MDIO for the whole frame, sends turnaround 10 and then bits 15:0 MSB first. After completion, bits 15:0 still hold the sent value.
- R6: A frame whose opcode bit 19 is 1 is a read. The master releases MDIO during turnaround and the 16 data bits, samples MDIO on each MDC rising edge, and places the 16 sampled bits, MSB first, in bits 15:0 when busy clears.
- R7: Accepting a read sets bits 15:0 to 0. A read therefore never returns an earlier value, and an address with no PHY present returns 0xFFFF from the pulled-up line.
- R8: MDC is low whenever busy is 0. The master changes its MDIO output only in the clock cycle right after an MDC falling edge.
- R9: On completion, a Clause 45 frame with opcode 0 loads `c45_ptr` with bits 15:0. A Clause 45 frame with opcode 2 adds one to `c45_ptr`. All other frames, and idle time, leave `c45_ptr` unchanged.
- R10: Busy stays 1 for exactly 64 MDC periods, that is 128×`HALF_CYC` clock cycles, counted from the clock edge that accepts the command.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Value written to the command word |
| reg_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| c45_ptr | output | 16 | Clause 45 register address held by the master |

## Verification
The hardest situation to produce is a read of a missing PHY that directly follows a successful read. A stale-data fault only shows up in that order. The bench's PHY model answers only addresses whose top bit is 0, so both directed and random reads alternate between present and absent devices. Each result is compared with either a model value or 0xFFFF.

A second hard case is a write that lands in the middle of a frame. The bench injects one at a fixed cycle inside the busy window of randomly chosen frames. It then checks the whole captured bit stream and the held fields.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_BITS  = 32;
    localparam int HDR_BITS  = 14;
    localparam int TURN_BITS = 2;
    localparam int DATA_BITS = 16;
    localparam int CNT_W     = $clog2(PRE_BITS + 1);
    localparam int SHIFT_W   = HDR_BITS + TURN_BITS + DATA_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } mdio_state_e;

    // Held command fields, laid out as bits 29:0 of the command word
    typedef struct packed {
        logic [4:0]           fld;
        logic [4:0]           phy;
        logic [1:0]           op;
        logic [1:0]           ftype;
        logic [DATA_BITS-1:0] data;
    } mdio_cmd_t;

    function automatic logic op_is_read(input logic [1:0] op);
        return op[1];
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          wrap;

    assign wrap     = (cnt_q == CW'(HALF_CYC - 1));
    assign rise_stb = run && wrap && !mdc_q;
    assign fall_stb = run && wrap && mdc_q;
    assign mdc      = mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
    parameter int TX_W = 32,
    parameter int RX_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_word,
    input  logic            shift,
    input  logic            capture,
    input  logic            sin,
    output logic            sout,
    output logic [RX_W-1:0] rx_word
);
    logic [TX_W-1:0] tx_q;
    logic [RX_W-1:0] rx_q;

    assign sout    = tx_q[TX_W-1];
    assign rx_word = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '1;
            rx_q <= '0;
        end else begin
            if (load)
                tx_q <= load_word;
            else if (shift)
                tx_q <= {tx_q[TX_W-2:0], 1'b1};
            if (capture)
                rx_q <= {rx_q[RX_W-2:0], sin};
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CYC = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i,
    output logic [15:0] c45_ptr
);
    mdio_state_e      state_q, state_d;
    logic [CNT_W-1:0] bit_cnt_q;
    mdio_cmd_t        cmd_q;
    logic [15:0]      ptr_q;
    logic             busy;
    logic             start;
    logic             rise_stb, fall_stb;
    logic             last_bit;
    logic             finish;
    logic             is_rd;
    logic             sout;
    logic [DATA_BITS-1:0] rx_word;
    logic [SHIFT_W-1:0]   frame_word;
    logic [CNT_W-1:0]     limit;

    assign busy      = (state_q != ST_IDLE);
    assign start     = reg_wr_en && !busy && reg_wdata[31] && !reg_wdata[17];
    assign is_rd     = op_is_read(cmd_q.op);
    assign reg_rdata = {busy, !busy, cmd_q};
    assign c45_ptr   = ptr_q;

    // start code, opcode, PHY, reg/dev, turnaround 10, data
    assign frame_word = {1'b0, reg_wdata[16], reg_wdata[19:18], reg_wdata[24:20],
                         reg_wdata[29:25], 2'b10, reg_wdata[15:0]};

    always_comb begin
        unique case (state_q)
            ST_PREAMBLE: limit = CNT_W'(PRE_BITS);
            ST_HEADER:   limit = CNT_W'(HDR_BITS);
            ST_TURN:     limit = CNT_W'(TURN_BITS);
            ST_DATA:     limit = CNT_W'(DATA_BITS);
            default:     limit = CNT_W'(1);
        endcase
    end

    assign last_bit = (bit_cnt_q == limit - 1'b1);
    assign finish   = (state_q == ST_DATA) && fall_stb && last_bit;

    mdio_clkgen #(.HALF_CYC(HALF_CYC)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_shifter #(.TX_W(SHIFT_W), .RX_W(DATA_BITS)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_word (frame_word),
        .shift     (fall_stb && busy && (state_q != ST_PREAMBLE)),
        .capture   (rise_stb && (state_q == ST_DATA) && is_rd),
        .sin       (mdio_i),
        .sout      (sout),
        .rx_word   (rx_word)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_stb && last_bit) state_d = ST_HEADER;
            ST_HEADER:   if (fall_stb && last_bit) state_d = ST_TURN;
            ST_TURN:     if (fall_stb && last_bit) state_d = ST_DATA;
            ST_DATA:     if (fall_stb && last_bit) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                bit_cnt_q <= '0;
            else if (fall_stb)
                bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // Command fields, read result and Clause 45 address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            ptr_q <= '0;
        end else if (start) begin
            cmd_q <= mdio_cmd_t'(reg_wdata[29:0]);
            if (op_is_read(reg_wdata[19:18]))
                cmd_q.data <= '0;
        end else if (finish) begin
            if (is_rd)
                cmd_q.data <= rx_word;
            if (cmd_q.ftype == 2'd0) begin
                if (cmd_q.op == 2'd0)
                    ptr_q <= cmd_q.data;
                else if (cmd_q.op == 2'd2)
                    ptr_q <= ptr_q + 16'd1;
            end
        end
    end

    // Pin outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:     begin mdio_oe = 1'b0;   mdio_o = 1'b1; end
            ST_PREAMBLE: begin mdio_oe = 1'b1;   mdio_o = 1'b1; end
            ST_HEADER:   begin mdio_oe = 1'b1;   mdio_o = sout; end
            ST_TURN,
            ST_DATA:     begin mdio_oe = !is_rd; mdio_o = sout; end
            default:     begin mdio_oe = 1'b0;   mdio_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [15:0] c45_ptr
);
    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[31] && reg_wr_en && reg_wdata[31] && !reg_wdata[17]) |=> reg_rdata[31]);

    // R2
    bad_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[31] && reg_wr_en && reg_wdata[17]) |=> $stable(reg_rdata));

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31] |=> $stable(reg_rdata[29:16]));

    // R5
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[31] && !reg_rdata[19]) |-> mdio_oe);

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(reg_rdata[31]) && reg_rdata[19]) |-> (reg_rdata[15:0] == 16'h0000));

    // R8
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[31] |-> !mdc);

    // R8
    mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc));

    // R9
    ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[31] |=> $stable(c45_ptr));
endmodule

bind mdio_master mdio_master_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .c45_ptr   (c45_ptr)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic [15:0] c45_ptr;
    logic        phy_en = 1'b0;
    logic        phy_bit = 1'b1;
    wire         line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

    int total = 0;
    int bad = 0;
    int k = 0;
    logic bits [0:63];
    logic [15:0] ptr_m = '0;

    always #5 clk = ~clk;

    mdio_master #(.HALF_CYC(HALF)) i_mdio_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (wr_en),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (line),
        .c45_ptr   (c45_ptr)
    );

    function automatic logic [15:0] phy_val(input logic [4:0] phy, input logic [4:0] fld);
        return {phy, fld, phy ^ fld, 1'b1};
    endfunction

    // Bus monitor: record every bit on MDC rising edges
    always @(posedge mdc) begin
        if (k < 64) bits[k] = line;
        k = k + 1;
    end

    // PHY model: answers reads at PHY addresses with top bit 0
    always @(negedge mdc) begin
        logic [4:0]  ph;
        logic [4:0]  fl;
        logic [15:0] pv;
        if (k >= 47 && k < 64 && bits[34] === 1'b1 && bits[36] === 1'b0) begin
            ph = {bits[36], bits[37], bits[38], bits[39], bits[40]};
            fl = {bits[41], bits[42], bits[43], bits[44], bits[45]};
            pv = phy_val(ph, fl);
            phy_en  = 1'b1;
            phy_bit = (k == 47) ? 1'b0 : pv[63-k];
        end else begin
            phy_en = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_txn(input bit c22, input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] fld, input logic [15:0] dat, input bit inj);
        logic [31:0] w;
        logic [63:0] e;
        logic [15:0] expd;
        int n;
        int mism;
        bit rd;
        w  = {1'b1, 1'b0, fld, phy, op, 1'b0, c22, dat};
        rd = op[1];
        e  = {32'hFFFF_FFFF, 1'b0, c22, op, phy, fld, 2'b10, dat};
        k  = 0;
        @(negedge clk); wr_en = 1'b1; wdata = w;
        @(negedge clk); wr_en = 1'b0;
        check(rdata[31] == 1'b1, "R1", "busy after start", {31'd0, rdata[31]}, 32'd1);
        if (rd) check(rdata[15:0] == 16'h0, "R7", "data cleared at read start", {16'd0, rdata[15:0]}, 32'd0);
        n = 0;
        while (rdata[31] && n < 5000) begin
            n++;
            if (inj && n == 40) begin wr_en = 1'b1; wdata = $urandom | 32'h8000_0000; end
            else wr_en = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;
        check(n == 128 * HALF, "R10", "busy duration", n, 128 * HALF);
        mism = 0;
        for (int i = 0; i < 46; i++) if (bits[i] !== e[63-i]) mism++;
        check(mism == 0, "R4", "preamble and header bits", mism, 0);
        if (!rd) begin
            mism = 0;
            for (int i = 46; i < 64; i++) if (bits[i] !== e[63-i]) mism++;
            check(mism == 0, "R5", "turnaround and data bits", mism, 0);
        end
        expd = rd ? ((phy[4] == 1'b0) ? phy_val(phy, fld) : 16'hFFFF) : dat;
        check(rdata[15:0] == expd, rd ? "R6" : "R5", "data field", {16'd0, rdata[15:0]}, {16'd0, expd});
        check(rdata[29:16] == w[29:16], "R3", "held fields", {18'd0, rdata[29:16]}, {18'd0, w[29:16]});
        check(rdata[31:30] == 2'b01, "R1", "busy clear and ready", {30'd0, rdata[31:30]}, 32'd1);
        check(mdc == 1'b0, "R8", "mdc low when idle", {31'd0, mdc}, 32'd0);
        if (!c22) begin
            if (op == 2'd0) ptr_m = dat;
            else if (op == 2'd2) ptr_m = ptr_m + 16'd1;
        end
        check(c45_ptr == ptr_m, "R9", "c45 address", {16'd0, c45_ptr}, {16'd0, ptr_m});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] snap;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdata == 32'h4000_0000, "R1", "reset word", rdata, 32'h4000_0000);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R8", "reset pins", {30'd0, mdc, mdio_oe}, 32'd0);
        check(c45_ptr == 16'h0, "R9", "reset c45 address", {16'd0, c45_ptr}, 32'd0);

        // Directed: a Clause 22 write, then a read of a present PHY and an absent one
        do_txn(1'b1, 2'd1, 5'd3, 5'd9, 16'hA5C3, 1'b0);
        do_txn(1'b1, 2'd2, 5'd3, 5'd2, 16'h1234, 1'b0);
        do_txn(1'b1, 2'd2, 5'd20, 5'd2, 16'h0000, 1'b0);   // R7: absent PHY gives 0xFFFF

        // R2: invalid frame type and busy bit clear are both ignored
        snap = rdata;
        @(negedge clk); wr_en = 1'b1; wdata = 32'h8003_7777;
        @(negedge clk); wr_en = 1'b0;
        check(rdata == snap, "R2", "frame type 3 ignored", rdata, snap);
        @(negedge clk); wr_en = 1'b1; wdata = 32'h0001_5555;
        @(negedge clk); wr_en = 1'b0;
        repeat (2 * HALF) @(negedge clk);
        check(rdata == snap && mdc == 1'b0, "R2", "busy-clear write ignored", rdata, snap);

        // Directed Clause 45: address, read with increment twice, then write
        do_txn(1'b0, 2'd0, 5'd6, 5'd1, 16'hFFFF, 1'b0);
        do_txn(1'b0, 2'd2, 5'd6, 5'd1, 16'h0000, 1'b0);
        do_txn(1'b0, 2'd2, 5'd6, 5'd1, 16'h0000, 1'b0);
        do_txn(1'b0, 2'd1, 5'd6, 5'd1, 16'h0F0F, 1'b1);    // R3: write injected mid-frame
        do_txn(1'b0, 2'd3, 5'd31, 5'd4, 16'h0000, 1'b0);

        for (int t = 0; t < 24; t++) begin
            logic [31:0] r;
            r = $urandom;
            do_txn(r[0], r[2:1], r[7:3], r[12:8], r[28:13], (r[30:29] == 2'b00));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule